// File: doc/BRIEF.md
# Clock-Recovery Coast Window Generator

This block produces the coast signal that holds a downstream line-locked clock-recovery loop steady while vertical sync is present, because horizontal sync pulses are missing or distorted in that interval. The coast can come from one of two places. The first is an external coast pin, whose active level the block works out for itself or takes from a user bit. The second is a window that the block builds around vertical sync.

In the vertical-sync mode the block counts horizontal sync strobes between successive vertical sync leading edges, which gives the number of lines in the previous frame. It uses that count to open the window a programmable number of lines (pre-coast) before the next expected leading edge. The window stays open while vertical sync is high. After the trailing edge it stays open for a further programmable number of horizontal syncs (post-coast). Until one complete frame has been measured, pre-coast has no effect and the window opens at the leading edge of vertical sync.

All inputs are synchronous to the pixel clock. The horizontal sync input is a one-cycle strobe and vertical sync is active high. The coast output is registered, so it reacts to its inputs one clock after they are sampled.

Top module: `coast_window_gen`

## Requirements
- R1: While reset is applied, and on the first cycle after it is released, `coast_out` is 0 and `coast_pol_status` is 1 (active high).
- R2: With `coast_src_sel`=0 and `pol_override`=0, `coast_out` in cycle n+1 is 1 exactly when `coast_pin` in cycle n equals the detected polarity `coast_pol_status` (1 = active high, 0 = active low).
- R3: With `coast_src_sel`=1 and both `pre_count` and `post_count` at 0, `coast_out` equals `vsync_in` delayed by one clock. While `vsync_in` is high in vertical-sync mode, `coast_out` is 1 on the next cycle.
- R4: The line total is the number of `hsync_stb` pulses between two successive rising edges of `vsync_in`. A strobe that coincides with a rising edge counts as the first line of the new frame. Once a total T is known and 0 < `pre_count` < T, the strobe that brings the line count since the last leading edge to T − `pre_count` raises `coast_out` on the next cycle.
- R5: Until two rising edges of `vsync_in` have been seen after reset, `pre_count` is ignored, and in vertical-sync mode the window opens on the cycle after the rising edge of `vsync_in`.
- R6: After the falling edge of `vsync_in` the window stays open until the `post_count`-th following `hsync_stb`, and `coast_out` drops on the cycle after that strobe. With `post_count`=0 it drops on the cycle after the falling edge.
- R7: A `pre_count` equal to or greater than the measured line total is ignored, and the window opens at the rising edge of `vsync_in`.
- R8: The detector compares the clocks `coast_pin` spends high and low over each frame, counted from one `vsync_in` rising edge to the next. At the next rising edge `coast_pol_status` becomes 1 if the pin was low for more clocks, becomes 0 if it was high for more clocks, and is unchanged on a tie.
- R9: With `coast_src_sel`=0 and `pol_override`=1, `coast_out` in cycle n+1 is 1 exactly when `coast_pin` equals `pol_user` in cycle n. `coast_pol_status` still reports the detected polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_stb | input | 1 | One-cycle horizontal sync strobe |
| vsync_in | input | 1 | Vertical sync, active high |
| coast_pin | input | 1 | External coast input, polarity unknown |
| pre_count | input | 8 | Lines of coast before the expected vertical sync |
| post_count | input | 8 | Lines of coast after the vertical sync trailing edge |
| coast_src_sel | input | 1 | 0 = external pin, 1 = vertical-sync window |
| pol_override | input | 1 | 1 = use pol_user as the pin polarity |
| pol_user | input | 1 | User pin polarity, 1 = active high |
| coast_out | output | 1 | Registered coast to the clock-recovery loop |
| coast_pol_status | output | 1 | Detected coast pin polarity, 1 = active high |

## Verification
The bench first runs frames with a non-zero pre-coast straight after reset. A design that trusts an unmeasured line total would open the window at a random line instead of at the leading edge. Pre-coast is then set larger than the frame. A design that wraps the subtraction would raise coast early in the frame rather than ignore the setting. Post-coast is tried at zero and at several lines, which catches an off-by-one on the closing strobe. The pin mode is run with a mostly-low pin and then a mostly-high pin, so a polarity detector that inverts its decision, updates outside the frame edge, or lets the override alter the reported status shows up as a coast that is inverted or a status bit that is wrong.

// File: rtl/coast_pkg.sv
package coast_pkg;

    typedef enum logic {
        SRC_PIN   = 1'b0,
        SRC_VSYNC = 1'b1
    } coast_src_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } vs_edge_t;

endpackage

// File: rtl/coast_line_tracker.sv
module coast_line_tracker
    import coast_pkg::*;
#(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync_stb,
    input  logic              vsync_in,
    output vs_edge_t          edge_o,
    output logic [LINE_W-1:0] line_cnt_o,
    output logic [LINE_W-1:0] total_o,
    output logic              valid_o
);

    localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

    typedef struct packed {
        logic              vs;
        logic              seen;
        logic              valid;
        logic [LINE_W-1:0] lines;
        logic [LINE_W-1:0] total;
    } trk_t;

    trk_t st_q, st_d;

    assign edge_o.rise = vsync_in & ~st_q.vs;
    assign edge_o.fall = ~vsync_in & st_q.vs;

    always_comb begin
        st_d    = st_q;
        st_d.vs = vsync_in;
        if (edge_o.rise) begin
            st_d.total = st_q.lines;
            st_d.valid = st_q.seen | st_q.valid;
            st_d.seen  = 1'b1;
            st_d.lines = hsync_stb ? LINE_W'(1) : '0;
        end else if (hsync_stb && st_q.lines != LINE_MAX) begin
            st_d.lines = st_q.lines + LINE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line_cnt_o = st_q.lines;
    assign total_o    = st_q.total;
    assign valid_o    = st_q.valid;

    // R5: a total is only trusted after a second leading edge
    p_valid_after_seen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.seen) |=> !st_q.valid);

endmodule

// File: rtl/coast_vs_window.sv
module coast_vs_window
    import coast_pkg::*;
#(
    parameter int LINE_W = 11,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync_stb,
    input  logic              vsync_in,
    input  vs_edge_t          edge_i,
    input  logic [LINE_W-1:0] line_cnt_i,
    input  logic [LINE_W-1:0] total_i,
    input  logic              valid_i,
    input  logic [CNT_W-1:0]  pre_count,
    input  logic [CNT_W-1:0]  post_count,
    output logic              win_next_o
);

    typedef struct packed {
        logic             pre;
        logic [CNT_W-1:0] post_left;
    } win_t;

    win_t st_q, st_d;

    logic [LINE_W-1:0] pre_ext;
    logic [LINE_W-1:0] start_line;
    logic              pre_hit;

    assign pre_ext    = LINE_W'(pre_count);
    assign start_line = total_i - pre_ext;

    always_comb begin
        pre_hit = valid_i && hsync_stb && !vsync_in
               && (pre_count != '0) && (total_i > pre_ext)
               && ((line_cnt_i + LINE_W'(1)) == start_line);

        st_d = st_q;
        if (edge_i.rise) begin
            st_d.pre       = 1'b0;
            st_d.post_left = '0;
        end else begin
            if (pre_hit) st_d.pre = 1'b1;
            if (edge_i.fall)
                st_d.post_left = post_count;
            else if (hsync_stb && st_q.post_left != '0)
                st_d.post_left = st_q.post_left - CNT_W'(1);
        end
        win_next_o = vsync_in | st_d.pre | (st_d.post_left != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: zero post-coast closes immediately after the trailing edge
    p_post_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i.fall && post_count == '0) |=> (!st_q.pre && st_q.post_left == '0));

    // R5: no early opening without a measured frame
    p_pre_needs_total_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i) |-> !st_q.pre);

endmodule

// File: rtl/coast_pol_detect.sv
module coast_pol_detect #(
    parameter int BAL_W = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic coast_pin,
    input  logic frame_start,
    output logic det_pol_o
);

    localparam logic signed [BAL_W-1:0] BAL_MAX = {1'b0, {(BAL_W-1){1'b1}}};
    localparam logic signed [BAL_W-1:0] BAL_MIN = {1'b1, {(BAL_W-1){1'b0}}};

    typedef struct packed {
        logic                    pol;
        logic signed [BAL_W-1:0] bal;
    } det_t;

    det_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (frame_start) begin
            if (st_q.bal < 0)      st_d.pol = 1'b1;
            else if (st_q.bal > 0) st_d.pol = 1'b0;
            st_d.bal = coast_pin ? BAL_W'(1) : {BAL_W{1'b1}};
        end else if (coast_pin) begin
            if (st_q.bal != BAL_MAX) st_d.bal = st_q.bal + BAL_W'(1);
        end else begin
            if (st_q.bal != BAL_MIN) st_d.bal = st_q.bal - BAL_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pol <= 1'b1;
            st_q.bal <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign det_pol_o = st_q.pol;

    // R8: the polarity decision moves only at a frame edge
    p_status_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start) |=> $stable(st_q.pol));

endmodule

// File: rtl/coast_window_gen.sv
module coast_window_gen
    import coast_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int LINE_W = 11,
    parameter int BAL_W  = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync_stb,
    input  logic             vsync_in,
    input  logic             coast_pin,
    input  logic [CNT_W-1:0] pre_count,
    input  logic [CNT_W-1:0] post_count,
    input  logic             coast_src_sel,
    input  logic             pol_override,
    input  logic             pol_user,
    output logic             coast_out,
    output logic             coast_pol_status
);

    vs_edge_t          vs_edge;
    logic [LINE_W-1:0] line_cnt;
    logic [LINE_W-1:0] line_total;
    logic              total_valid;
    logic              win_next;
    logic              det_pol;

    coast_line_tracker #(.LINE_W(LINE_W)) u_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .hsync_stb  (hsync_stb),
        .vsync_in   (vsync_in),
        .edge_o     (vs_edge),
        .line_cnt_o (line_cnt),
        .total_o    (line_total),
        .valid_o    (total_valid)
    );

    coast_vs_window #(.LINE_W(LINE_W), .CNT_W(CNT_W)) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .hsync_stb  (hsync_stb),
        .vsync_in   (vsync_in),
        .edge_i     (vs_edge),
        .line_cnt_i (line_cnt),
        .total_i    (line_total),
        .valid_i    (total_valid),
        .pre_count  (pre_count),
        .post_count (post_count),
        .win_next_o (win_next)
    );

    coast_pol_detect #(.BAL_W(BAL_W)) u_pol (
        .clk         (clk),
        .rst_n       (rst_n),
        .coast_pin   (coast_pin),
        .frame_start (vs_edge.rise),
        .det_pol_o   (det_pol)
    );

    typedef struct packed {
        logic coast;
    } top_t;

    top_t       st_q, st_d;
    coast_src_e src;
    logic       eff_pol;

    always_comb begin
        src      = coast_src_e'(coast_src_sel);
        eff_pol  = pol_override ? pol_user : det_pol;
        st_d     = st_q;
        st_d.coast = (src == SRC_VSYNC) ? win_next : (coast_pin == eff_pol);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign coast_out        = st_q.coast;
    assign coast_pol_status = det_pol;

    // R3: vertical sync is always inside the window
    p_vsync_covers_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (coast_src_sel && vsync_in) |=> coast_out);

    // R9: the user polarity drives the pin path
    p_pin_user_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!coast_src_sel && pol_override) |=> (coast_out == ($past(coast_pin) == $past(pol_user))));

    // R2: the detected polarity drives the pin path
    p_pin_detect_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!coast_src_sel && !pol_override) |=> (coast_out == ($past(coast_pin) == $past(coast_pol_status))));

endmodule

// File: tb/coast_window_gen_tb_top.sv
`timescale 1ns/1ps
module coast_window_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync_stb = 1'b0;
    logic       vsync_in = 1'b0;
    logic       coast_pin = 1'b0;
    logic [7:0] pre_count = 8'd0;
    logic [7:0] post_count = 8'd0;
    logic       coast_src_sel = 1'b1;
    logic       pol_override = 1'b0;
    logic       pol_user = 1'b0;
    logic       coast_out;
    logic       coast_pol_status;

    always #2.5 clk = ~clk;

    coast_window_gen dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .hsync_stb        (hsync_stb),
        .vsync_in         (vsync_in),
        .coast_pin        (coast_pin),
        .pre_count        (pre_count),
        .post_count       (post_count),
        .coast_src_sel    (coast_src_sel),
        .pol_override     (pol_override),
        .pol_user         (pol_user),
        .coast_out        (coast_out),
        .coast_pol_status (coast_pol_status)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 0;
    string cur_req  = "R1";

    // behavioural reference, integers only
    int m_lines = 0, m_total = 0, m_frames = 0, m_bal = 0, m_post = 0;
    bit m_vs = 0, m_pre = 0, m_det = 1, m_coast = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lines = 0; m_total = 0; m_frames = 0; m_bal = 0; m_post = 0;
            m_vs = 0; m_pre = 0; m_det = 1; m_coast = 0;
        end else begin
            bit up, dn, pol, win;
            up  = vsync_in && !m_vs;
            dn  = !vsync_in && m_vs;
            pol = pol_override ? pol_user : m_det;
            if (up) begin
                m_pre = 0; m_post = 0;
            end else begin
                if (m_frames >= 2 && hsync_stb && !vsync_in && pre_count > 0
                    && m_total > pre_count && (m_total - m_lines - 1) == pre_count)
                    m_pre = 1;
                if (dn) m_post = post_count;
                else if (hsync_stb && m_post > 0) m_post--;
            end
            win = vsync_in || m_pre || (m_post > 0);
            m_coast = coast_src_sel ? win : (coast_pin == pol);
            if (up) begin
                if (m_bal < 0) m_det = 1;
                else if (m_bal > 0) m_det = 0;
                m_bal = coast_pin ? 1 : -1;
                m_total = m_lines;
                m_lines = hsync_stb ? 1 : 0;
                m_frames++;
            end else begin
                m_bal += coast_pin ? 1 : -1;
                if (hsync_stb) m_lines++;
            end
            m_vs = vsync_in;
        end
    end

    task automatic check(string req, logic act, logic exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(cur_req, coast_out, m_coast, "coast_out");
            check(cur_req, coast_pol_status, m_det, "coast_pol_status");
        end
    end

    task automatic frame(int nl, int vs_at, int vs_len, logic idle, int llen);
        for (int l = 0; l < nl; l++) begin
            for (int c = 0; c < llen; c++) begin
                @(posedge clk); #1;
                hsync_stb = (c == 0);
                if (c == 2 && l == vs_at) vsync_in = 1'b1;
                if (c == 2 && l == vs_at + vs_len) vsync_in = 1'b0;
                coast_pin = vsync_in ? ~idle : idle;
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        check("R1", coast_out, 1'b0, "coast_out in reset");
        check("R1", coast_pol_status, 1'b1, "status in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", coast_out, 1'b0, "coast_out after reset");
        check("R1", coast_pol_status, 1'b1, "status after reset");

        // R5: pre-coast set but no measured frame yet
        cur_req = "R5"; pre_count = 8'd4; post_count = 8'd0; coast_src_sel = 1'b1;
        frame(20, 16, 2, 1'b0, 8);
        frame(20, 16, 2, 1'b0, 8);
        // R4: window opens four lines ahead once the total is known
        cur_req = "R4";
        frame(20, 16, 2, 1'b0, 8);
        frame(20, 16, 2, 1'b0, 8);
        pre_count = 8'd1;
        frame(20, 16, 2, 1'b0, 8);
        // R3: window equals vertical sync
        cur_req = "R3"; pre_count = 8'd0;
        frame(20, 16, 2, 1'b0, 8);
        frame(20, 10, 3, 1'b0, 8);
        // R6: post-coast lines after the trailing edge
        cur_req = "R6"; post_count = 8'd3;
        frame(20, 10, 3, 1'b0, 8);
        post_count = 8'd1;
        frame(20, 10, 3, 1'b0, 8);
        post_count = 8'd0;
        frame(20, 10, 3, 1'b0, 8);
        // R7: pre-coast not smaller than the total
        cur_req = "R7"; pre_count = 8'd20;
        frame(20, 10, 3, 1'b0, 8);
        pre_count = 8'd30;
        frame(20, 10, 3, 1'b0, 8);
        pre_count = 8'd0;
        // R2 and R8: pin path with a mostly-low pin, then a mostly-high pin
        cur_req = "R2"; coast_src_sel = 1'b0;
        frame(20, 10, 3, 1'b0, 8);
        frame(20, 10, 3, 1'b0, 8);
        cur_req = "R8";
        frame(20, 10, 3, 1'b1, 8);
        frame(20, 10, 3, 1'b1, 8);
        @(negedge clk);
        check("R8", coast_pol_status, 1'b0, "status after high-idle frames");
        // R9: user polarity replaces the detected one
        cur_req = "R9"; pol_override = 1'b1; pol_user = 1'b1;
        frame(20, 10, 3, 1'b1, 8);
        @(negedge clk);
        check("R9", coast_pol_status, 1'b0, "status unaffected by override");
        pol_user = 1'b0;
        frame(20, 10, 3, 1'b0, 8);
        repeat (4) @(posedge clk);
        finish_run();
    end

endmodule